// File: doc/BRIEF.md
# DTMF Steering Guard-Time Validator

This block sits behind a tone-pair detector in a DTMF receiver. The detector supplies a flag that is high while it recognises a valid tone pair, together with the 4-bit code of that pair. The block decides whether a tone and the silence after it have each lasted long enough to count. A burst that is too short is rejected, and a brief drop-out inside a tone is bridged. The hysteresis that an external resistor-capacitor network would give is built here from a shared millisecond-scale tick prescaler and two saturating guard counters: one measures presence and one measures absence.

When a tone qualifies, the block copies the digit code into the receive register and raises a guard-active indication. After a short settling delay it raises the delayed steering flag and issues a one-clock receive-full pulse toward the register interface. The receive register keeps that digit through the following pause and any later rejected bursts, until the next tone qualifies. While the receiver is disabled or call-progress mode is selected, no digit is registered.

With the defaults (50,000 clocks per tick, 30-tick guards), tones of 40 ms are accepted, bursts of 20 ms are rejected, and drop-outs of 20 ms are bridged.

Top module: `dtmf_guard_validator`

## Requirements
- R1: A tone is registered at the clock edge that follows TONE_TICKS*TICK_CYCLES+1 consecutive clock samples with est_i high. A burst with one sample fewer leaves digit_o, gt_o and dstd_o unchanged.
- R2: Once a tone is registered, its end is accepted at the clock edge that follows IDLE_TICKS*TICK_CYCLES+1 consecutive samples with est_i low. A shorter low stretch changes neither gt_o, dstd_o nor digit_o.
- R3: At the registration edge, digit_o takes the digit_i value sampled in that cycle, and gt_o rises at the same edge.
- R4: dstd_o rises SETTLE_CYC clock edges after the registration edge, and it falls at the same edge as gt_o.
- R5: rx_full_o is high for exactly one cycle per registered tone, at the edge where dstd_o rises.
- R6: digit_o holds its value until the next registration, including across the end of the tone and across rejected bursts.
- R7: While rx_en_i is low or cp_mode_i is high, no tone is registered: gt_o, dstd_o, rx_full_o and digit_o stay as they were.
- R8: The digit code passes through unchanged in this encoding: keys 1 to 9 map to 1 to 9, key 0 to 10, * to 11, # to 12, A, B and C to 13, 14 and 15, and D to 0.
- R9: During reset and at reset release, digit_o is 0 and gt_o, dstd_o and rx_full_o are low.
- R10: gt_o stays high from registration until the end of the tone is accepted. dstd_o is never high while gt_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| est_i | input | 1 | Early steering: high while a valid tone pair is detected |
| digit_i | input | 4 | Decoded digit code from the tone detector |
| rx_en_i | input | 1 | Receiver enable; low blocks registration |
| cp_mode_i | input | 1 | Call-progress mode; high blocks registration |
| digit_o | output | 4 | Receive register: last registered digit code |
| gt_o | output | 1 | Guard-active: high while a registered tone is held |
| dstd_o | output | 1 | Delayed steering flag |
| rx_full_o | output | 1 | One-cycle receive-full event |

## Verification
The bench builds the block with TICK_CYCLES=4, TONE_TICKS=3, IDLE_TICKS=3 and SETTLE_CYC=2. This shrinks both guard windows to 13 samples, so the accept and reject boundaries can be probed one sample apart, and a whole tone-pause sequence fits in a few dozen cycles. At this scale the run can cover every registration edge, the settling offset, bridged drop-outs, exact end-of-tone timing, the blocking modes and the full digit encoding.

// File: rtl/dgv_pkg.sv
package dgv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } dgv_state_e;

  // Bits needed to hold values 0..maxval (at least one bit).
  function automatic int unsigned dgv_width(input int unsigned maxval);
    if (maxval < 1) return 1;
    return $clog2(maxval + 1);
  endfunction

  // Consecutive clock samples a level must hold before the guard is met.
  function automatic int unsigned dgv_min_samples(input int unsigned ticks,
                                                  input int unsigned cycles_per_tick);
    return ticks * cycles_per_tick + 1;
  endfunction

endpackage

// File: rtl/dgv_tick_gen.sv
module dgv_tick_gen #(
  parameter int unsigned TICK_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  import dgv_pkg::*;

  localparam int unsigned PW = dgv_width(TICK_CYCLES - 1);
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] phase_q;
  logic          wrap;

  assign wrap = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i || wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // A level change restarts the phase, and that cycle never ticks.
  assign tick_o = wrap && !restart_i;

endmodule

// File: rtl/dgv_guard_cnt.sv
module dgv_guard_cnt #(
  parameter int unsigned LIMIT  = 30,
  parameter bit          ACTIVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic tick_i,
  output logic met_o
);
  import dgv_pkg::*;

  localparam int unsigned CW = dgv_width(LIMIT);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (level_i != ACTIVE) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q < LIM_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign met_o = (cnt_q >= LIM_V);

endmodule

// File: rtl/dgv_rx_fsm.sv
module dgv_rx_fsm #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_met_i,
  input  logic              absent_met_i,
  input  logic              blocked_i,
  input  logic [CODE_W-1:0] digit_i,
  output logic [CODE_W-1:0] digit_o,
  output logic              held_o,
  output logic              dstd_o,
  output logic              full_o,
  output logic              reg_evt_o,
  output logic              end_evt_o
);
  import dgv_pkg::*;

  localparam int unsigned SW = dgv_width(SETTLE_CYC - 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  dgv_state_e        st_q, st_d;
  logic [SW-1:0]     settle_q;
  logic [CODE_W-1:0] digit_q;
  logic              dstd_q, full_q;
  logic              settle_done;

  assign reg_evt_o   = (st_q == ST_IDLE) && present_met_i && !blocked_i;
  assign settle_done = (st_q == ST_SETTLE) && (settle_q == SETTLE_LAST);
  assign end_evt_o   = (st_q == ST_HELD) && absent_met_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (reg_evt_o)   st_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) st_d = ST_HELD;
      ST_HELD:   if (end_evt_o)   st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      settle_q <= '0;
      digit_q  <= '0;
      dstd_q   <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      full_q <= settle_done;
      if (reg_evt_o) begin
        digit_q  <= digit_i;
        settle_q <= '0;
      end else if (st_q == ST_SETTLE) begin
        settle_q <= settle_q + 1'b1;
      end
      if (settle_done) begin
        dstd_q <= 1'b1;
      end else if (end_evt_o) begin
        dstd_q <= 1'b0;
      end
    end
  end

  assign digit_o = digit_q;
  assign held_o  = (st_q != ST_IDLE);
  assign dstd_o  = dstd_q;
  assign full_o  = full_q;

endmodule

// File: rtl/dtmf_guard_validator.sv
module dtmf_guard_validator #(
  parameter int unsigned TICK_CYCLES = 50000,
  parameter int unsigned TONE_TICKS  = 30,
  parameter int unsigned IDLE_TICKS  = 30,
  parameter int unsigned SETTLE_CYC  = 2,
  parameter int unsigned CODE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              est_i,
  input  logic [CODE_W-1:0] digit_i,
  input  logic              rx_en_i,
  input  logic              cp_mode_i,
  output logic [CODE_W-1:0] digit_o,
  output logic              gt_o,
  output logic              dstd_o,
  output logic              rx_full_o
);

  // Named internal events, brought out for the bound checker.
  logic       est_q;
  logic       level_change;
  logic       tick;
  logic [1:0] guard_met;   // [0] presence, [1] absence
  logic       blocked;
  logic       reg_evt;
  logic       end_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) est_q <= 1'b0;
    else        est_q <= est_i;
  end

  assign level_change = est_i ^ est_q;
  assign blocked      = !rx_en_i || cp_mode_i;

  dgv_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (level_change),
    .tick_o    (tick)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_guard
    dgv_guard_cnt #(
      .LIMIT  ((gi == 0) ? TONE_TICKS : IDLE_TICKS),
      .ACTIVE ((gi == 0) ? 1'b1 : 1'b0)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (est_q),
      .tick_i  (tick),
      .met_o   (guard_met[gi])
    );
  end

  dgv_rx_fsm #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .present_met_i (guard_met[0]),
    .absent_met_i  (guard_met[1]),
    .blocked_i     (blocked),
    .digit_i       (digit_i),
    .digit_o       (digit_o),
    .held_o        (gt_o),
    .dstd_o        (dstd_o),
    .full_o        (rx_full_o),
    .reg_evt_o     (reg_evt),
    .end_evt_o     (end_evt)
  );

endmodule

// File: rtl/dgv_guard_checker.sv
module dgv_guard_checker #(
  parameter int unsigned TICK_CYCLES = 50000,
  parameter int unsigned TONE_TICKS  = 30,
  parameter int unsigned IDLE_TICKS  = 30,
  parameter int unsigned CODE_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              est_i,
  input logic              rx_en_i,
  input logic              cp_mode_i,
  input logic [CODE_W-1:0] digit_o,
  input logic              gt_o,
  input logic              dstd_o,
  input logic              rx_full_o,
  input logic              reg_evt,
  input logic              end_evt
);
  import dgv_pkg::*;

  localparam int unsigned HI_MIN = dgv_min_samples(TONE_TICKS, TICK_CYCLES);
  localparam int unsigned LO_MIN = dgv_min_samples(IDLE_TICKS, TICK_CYCLES);
  localparam int unsigned HW = dgv_width(HI_MIN);
  localparam int unsigned LW = dgv_width(LO_MIN);

  // Independent run-length counters of the raw input level.
  logic [HW-1:0] hi_run;
  logic [LW-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (est_i) begin
        lo_run <= '0;
        if (hi_run < HW'(HI_MIN)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run < LW'(LO_MIN)) lo_run <= lo_run + 1'b1;
      end
    end
  end

  AST_REG_AFTER_TONE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_evt |-> (hi_run == HW'(HI_MIN)));                                  // R1
  AST_END_AFTER_IDLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> (lo_run == LW'(LO_MIN)));                                  // R2
  AST_FULL_WITH_DSTD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstd_o) |-> rx_full_o);                                          // R4
  AST_FULL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_o |=> !rx_full_o);                                             // R5
  AST_DIGIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_evt |=> $stable(digit_o));                                        // R6
  AST_NO_REG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_i || cp_mode_i) |-> !reg_evt);                                 // R7
  AST_DSTD_INSIDE_GT: assert property (@(posedge clk) disable iff (!rst_n)
    dstd_o |-> gt_o);                                                      // R10

endmodule

bind dtmf_guard_validator dgv_guard_checker #(
  .TICK_CYCLES (TICK_CYCLES),
  .TONE_TICKS  (TONE_TICKS),
  .IDLE_TICKS  (IDLE_TICKS),
  .CODE_W      (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .est_i     (est_i),
  .rx_en_i   (rx_en_i),
  .cp_mode_i (cp_mode_i),
  .digit_o   (digit_o),
  .gt_o      (gt_o),
  .dstd_o    (dstd_o),
  .rx_full_o (rx_full_o),
  .reg_evt   (reg_evt),
  .end_evt   (end_evt)
);

// File: tb/dtmf_guard_validator_bench.sv
`timescale 1ns/1ps
module dtmf_guard_validator_bench;

  localparam int CPT = 4;
  localparam int TGP = 3;
  localparam int TGA = 3;
  localparam int SET = 2;
  localparam int ACC_SAMPLES = TGP * CPT + 1;  // 13
  localparam int END_SAMPLES = TGA * CPT + 1;  // 13

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       est_i = 1'b0;
  logic [3:0] digit_i = 4'd0;
  logic       rx_en_i = 1'b1;
  logic       cp_mode_i = 1'b0;
  logic [3:0] digit_o;
  logic       gt_o, dstd_o, rx_full_o;

  int tests = 0;
  int fails = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  dtmf_guard_validator #(
    .TICK_CYCLES(CPT), .TONE_TICKS(TGP), .IDLE_TICKS(TGA), .SETTLE_CYC(SET), .CODE_W(4)
  ) u_dtmf_guard_validator (
    .clk(clk), .rst_n(rst_n), .est_i(est_i), .digit_i(digit_i),
    .rx_en_i(rx_en_i), .cp_mode_i(cp_mode_i), .digit_o(digit_o),
    .gt_o(gt_o), .dstd_o(dstd_o), .rx_full_o(rx_full_o)
  );

  always @(negedge clk) if (rx_full_o) pulses++;

  function automatic logic [3:0] key_code(input byte k);
    if (k >= "1" && k <= "9") return 4'(k - "0");
    case (k)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      default: return 4'd0;  // D
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Vector table: key, high samples, rx enable, call-progress, accepted
  localparam int NV = 10;
  localparam byte VKEY[NV] = '{"5", "9", "0", "3", "D", "7", "*", "#", "C", "1"};
  localparam int  VHI [NV] = '{13, 12, 30, 5, 20, 20, 16, 16, 16, 16};
  localparam bit  VEN [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1};
  localparam bit  VCP [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam bit  VACC[NV] = '{1, 0, 1, 0, 0, 0, 1, 1, 1, 1};

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] exp_digit;
    int p0;
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    check(digit_o == 4'd0, "R9 digit", digit_o, 0);
    check(gt_o == 1'b0, "R9 gt", gt_o, 0);
    check(dstd_o == 1'b0, "R9 dstd", dstd_o, 0);
    check(rx_full_o == 1'b0, "R9 full", rx_full_o, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // Exact registration timing, key 8
    @(negedge clk); est_i = 1'b1; digit_i = key_code("8"); p0 = pulses;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (k == ACC_SAMPLES - 1) begin
        check(gt_o == 1'b0, "R1 not yet", gt_o, 0);
        check(digit_o == 4'd0, "R1 digit unchanged", digit_o, 0);
      end
      if (k == ACC_SAMPLES) begin
        check(gt_o == 1'b1, "R3 gt rise", gt_o, 1);
        check(digit_o == 4'd8, "R3 digit latch", digit_o, 8);
        check(dstd_o == 1'b0, "R4 dstd early", dstd_o, 0);
      end
      if (k == ACC_SAMPLES + SET - 1) check(dstd_o == 1'b0, "R4 dstd early", dstd_o, 0);
      if (k == ACC_SAMPLES + SET) begin
        check(dstd_o == 1'b1, "R4 dstd rise", dstd_o, 1);
        check(rx_full_o == 1'b1, "R5 full pulse", rx_full_o, 1);
      end
      if (k == ACC_SAMPLES + SET + 1) check(rx_full_o == 1'b0, "R5 full width", rx_full_o, 0);
    end

    // Bridged drop-out one sample short, digit input changes meanwhile
    @(negedge clk); est_i = 1'b0; digit_i = 4'd4;
    repeat (END_SAMPLES - 1) @(posedge clk);
    @(negedge clk); est_i = 1'b1;
    repeat (10) @(posedge clk); #1;
    check(gt_o == 1'b1, "R2 dropout gt", gt_o, 1);
    check(dstd_o == 1'b1, "R2 dropout dstd", dstd_o, 1);
    check(digit_o == 4'd8, "R6 dropout digit", digit_o, 8);
    check(pulses - p0 == 1, "R5 one pulse", pulses - p0, 1);

    // Exact end-of-tone timing
    @(negedge clk); est_i = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1;
      if (k == END_SAMPLES - 1) begin
        check(gt_o == 1'b1, "R2 end early", gt_o, 1);
        check(dstd_o == 1'b1, "R10 dstd held", dstd_o, 1);
      end
      if (k == END_SAMPLES) begin
        check(gt_o == 1'b0, "R10 gt fall", gt_o, 0);
        check(dstd_o == 1'b0, "R4 dstd fall", dstd_o, 0);
        check(digit_o == 4'd8, "R6 kept after end", digit_o, 8);
      end
    end

    // Vector table: R1 R7 R8 R6
    exp_digit = 4'd8;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      digit_i = key_code(VKEY[v]); rx_en_i = VEN[v]; cp_mode_i = VCP[v];
      est_i = 1'b1; p0 = pulses;
      repeat (VHI[v]) @(posedge clk);
      @(negedge clk); est_i = 1'b0;
      repeat (20) @(posedge clk);
      @(negedge clk);
      if (VACC[v]) exp_digit = key_code(VKEY[v]);
      check(digit_o == exp_digit, "R8 R1 R7 digit", digit_o, exp_digit);
      check(pulses - p0 == int'(VACC[v]), "R1 R7 pulses", pulses - p0, int'(VACC[v]));
      check(gt_o == 1'b0, "R2 idle after", gt_o, 0);
      rx_en_i = 1'b1; cp_mode_i = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule